// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block runs on the host side of a parallel NOR-style flash and finds out whether an embedded program or erase operation has finished. After a start strobe it issues status reads in pairs, with no other bus cycle between the two reads of a pair. It then compares the toggle bit (bit 6 of the low byte) across the two reads. A bit that holds still means the operation is over. A bit that keeps changing means the device is still busy, unless the exceeded-time-limit flag (bit 5) is also set.

When bit 5 is seen, the poller makes one more pair of reads before it gives a verdict. The toggle may have stopped at the same moment the flag rose, so a pair that no longer toggles still counts as success. A recheck pair that still toggles means failure. The poller then writes the reset command so the device returns to array-read mode. A host pause input can park the poller between pairs. An iteration limit turns a device that never finishes into a failure. The 2-bit result is held until the next start.

Top module: `tbit_poller`

## Requirements
- R1: After reset, busy_o is 0, result_o is 00, and rd_o and wr_o are both 0.
- R2: While busy_o is 1 and pause_i has been 0 for the current and previous cycle, rd_o or wr_o is asserted in every cycle. A new read always follows an acknowledged read with no idle bus cycle between them.
- R3: If bit 6 of the two reads of a pair is equal, the poller finishes with result_o = 01 (success) and issues no write.
- R4: If bit 6 differs and bit 5 of the second read is 0, the poller starts another pair of reads at once (pause_i low), counting the pair toward the iteration limit.
- R5: If bit 6 differs and bit 5 of the second read is 1, the poller makes exactly one recheck pair. If bit 6 is equal within that pair, the result is 01.
- R6: If bit 6 still differs in the recheck pair, the poller issues a single write of data 0x00F0. It reports result_o = 10 (failure) only after that write is acknowledged.
- R7: With pause_i high when a toggling pair (bit 5 = 0) completes, the poller issues no bus cycles until pause_i falls. It then begins a fresh pair, using no stored toggle value.
- R8: After MAX_PAIRS consecutive toggling pairs with bit 5 = 0, the poller gives up, writes 0x00F0 and reports 10.
- R9: result_o reads 00 while busy_o is 1. Once the poller finishes, result_o holds its value until the next start strobe, and a start strobe while busy_o is 1 is ignored. The code 11 never appears.
- R10: Only bits 6 and 5 of the read data affect the outcome; all other bits are ignored.
- R11: rd_o and wr_o are never asserted together. Each strobe stays high until ack_i is seen, and wdata_o equals 0x00F0 whenever wr_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a status poll (one-cycle strobe) |
| pause_i | input | 1 | Hold polling between read pairs |
| rd_o | output | 1 | Read request, held until acknowledged |
| wr_o | output | 1 | Write request, held until acknowledged |
| wdata_o | output | 16 | Write data (reset command) |
| rdata_i | input | 16 | Read data from the flash |
| ack_i | input | 1 | Bus cycle acknowledge |
| busy_o | output | 1 | Poll in progress |
| result_o | output | 2 | 00 busy, 01 success, 10 failure |

## Verification
The bound checker watches the bus rules on every cycle. These are exclusive strobes held until acknowledge, the fixed write data, and the absence of idle bus cycles while polling runs unpaused. It also covers a result of 00 during a poll, a result frozen between polls, and no illegal result code. The bench scenarios are what show the decision logic: success on a steady toggle bit, the recheck after the time-limit flag with both of its outcomes, the iteration limit, and the pause and resume. Each scenario counts reads and writes through a scripted flash model, and it proves that bits other than 6 and 5 have no effect.

// File: rtl/tbit_pkg.sv
package tbit_pkg;

   typedef enum logic [1:0] {
      RES_BUSY = 2'b00,
      RES_OK   = 2'b01,
      RES_FAIL = 2'b10
   } tbit_result_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_HOLD,
      ST_RST
   } tbit_state_e;

endpackage

// File: rtl/tbit_toggle_cmp.sv
// Holds the toggle bit of the first read in a pair and compares it with
// the second read as that read is acknowledged.
module tbit_toggle_cmp #(
   parameter int DATA_W  = 16,
   parameter int TOG_BIT = 6,
   parameter int TMO_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap,
   input  logic [DATA_W-1:0] rdata,
   output logic              toggled,
   output logic              tmo_flag
);

   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   first_q <= 1'b0;
      else if (clr) first_q <= 1'b0;
      else if (cap) first_q <= rdata[TOG_BIT];
   end

   assign toggled  = first_q ^ rdata[TOG_BIT];
   assign tmo_flag = rdata[TMO_BIT];

endmodule

// File: rtl/tbit_pair_limit.sv
// Counts toggling pairs; flags the pair that would reach the limit.
module tbit_pair_limit #(
   parameter int MAX_PAIRS = 65535
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);

   localparam int CNT_W = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

   generate
      if (MAX_PAIRS == 0) begin : g_unlimited
         assign last = 1'b0;
      end else begin : g_limited
         logic [CNT_W-1:0] cnt_q;
         localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_PAIRS - 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + 1'b1;
         end

         assign last = (cnt_q == LAST_VAL);
      end
   endgenerate

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller #(
   parameter int              DATA_W    = 16,
   parameter int              TOG_BIT   = 6,
   parameter int              TMO_BIT   = 5,
   parameter int              MAX_PAIRS = 65535,
   parameter logic [15:0]     RESET_CMD = 16'h00F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pause_i,
   output logic              rd_o,
   output logic              wr_o,
   output logic [DATA_W-1:0] wdata_o,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              ack_i,
   output logic              busy_o,
   output logic [1:0]        result_o
);
   import tbit_pkg::*;

   generate
      if (DATA_W < 8)      begin : g_bad_width  $error("DATA_W must be at least 8");    end
      if (TOG_BIT > 7)     begin : g_bad_tog    $error("TOG_BIT must be in low byte");  end
      if (TMO_BIT > 7)     begin : g_bad_tmo    $error("TMO_BIT must be in low byte");  end
      if (TOG_BIT == TMO_BIT) begin : g_bad_same $error("status bits must differ");     end
      if (MAX_PAIRS < 0)   begin : g_bad_lim    $error("MAX_PAIRS must be >= 0");       end
   endgenerate

   tbit_state_e  state_q, state_d;
   tbit_result_e res_q, res_d;
   logic         res_load;
   logic         recheck_q, recheck_set, recheck_clr;
   logic         cap, cmp_clr, cnt_clr, cnt_inc;
   logic         toggled, tmo_flag, limit_last;

   tbit_toggle_cmp #(
      .DATA_W  (DATA_W),
      .TOG_BIT (TOG_BIT),
      .TMO_BIT (TMO_BIT)
   ) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (cmp_clr),
      .cap      (cap),
      .rdata    (rdata_i),
      .toggled  (toggled),
      .tmo_flag (tmo_flag)
   );

   tbit_pair_limit #(
      .MAX_PAIRS (MAX_PAIRS)
   ) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .last  (limit_last)
   );

   always_comb begin
      state_d     = state_q;
      res_d       = res_q;
      res_load    = 1'b0;
      recheck_set = 1'b0;
      recheck_clr = 1'b0;
      cap         = 1'b0;
      cmp_clr     = 1'b0;
      cnt_clr     = 1'b0;
      cnt_inc     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d     = ST_RD_A;
               res_d       = RES_BUSY;
               res_load    = 1'b1;
               recheck_clr = 1'b1;
               cnt_clr     = 1'b1;
               cmp_clr     = 1'b1;
            end
         end
         ST_RD_A: begin
            if (ack_i) begin
               cap     = 1'b1;
               state_d = ST_RD_B;
            end
         end
         ST_RD_B: begin
            if (ack_i) begin
               if (!toggled) begin
                  state_d  = ST_IDLE;
                  res_d    = RES_OK;
                  res_load = 1'b1;
               end else if (recheck_q) begin
                  state_d = ST_RST;
               end else if (tmo_flag) begin
                  recheck_set = 1'b1;
                  state_d     = ST_RD_A;
               end else if (limit_last) begin
                  state_d = ST_RST;
               end else begin
                  cnt_inc = 1'b1;
                  state_d = pause_i ? ST_HOLD : ST_RD_A;
               end
            end
         end
         ST_HOLD: begin
            if (!pause_i) begin
               cmp_clr = 1'b1;
               state_d = ST_RD_A;
            end
         end
         ST_RST: begin
            if (ack_i) begin
               state_d  = ST_IDLE;
               res_d    = RES_FAIL;
               res_load = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         res_q     <= RES_BUSY;
         recheck_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (res_load)         res_q     <= res_d;
         if (recheck_clr)      recheck_q <= 1'b0;
         else if (recheck_set) recheck_q <= 1'b1;
      end
   end

   assign rd_o     = (state_q == ST_RD_A) || (state_q == ST_RD_B);
   assign wr_o     = (state_q == ST_RST);
   assign wdata_o  = DATA_W'(RESET_CMD);
   assign busy_o   = (state_q != ST_IDLE);
   assign result_o = res_q;

endmodule

// File: rtl/tbit_poller_chk.sv
module tbit_poller_chk #(
   parameter int          DATA_W    = 16,
   parameter logic [15:0] RESET_CMD = 16'h00F0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              pause_i,
   input logic              rd_o,
   input logic              wr_o,
   input logic [DATA_W-1:0] wdata_o,
   input logic              ack_i,
   input logic              busy_o,
   input logic [1:0]        result_o
);

   a_r11_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_o && wr_o));

   a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o && !ack_i) |=> rd_o);

   a_r11_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_o && !ack_i) |=> wr_o);

   a_r11_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> (wdata_o == DATA_W'(RESET_CMD)));

   a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pause_i && !$past(pause_i)) |-> (rd_o || wr_o));

   a_r9_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (result_o == 2'b00));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));

   a_r9_legal: assert property (@(posedge clk) disable iff (!rst_n)
      result_o != 2'b11);

   a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!rd_o && !wr_o));

endmodule

bind tbit_poller tbit_poller_chk #(
   .DATA_W    (DATA_W),
   .RESET_CMD (RESET_CMD)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .pause_i  (pause_i),
   .rd_o     (rd_o),
   .wr_o     (wr_o),
   .wdata_o  (wdata_o),
   .ack_i    (ack_i),
   .busy_o   (busy_o),
   .result_o (result_o)
);

// File: tb/tbit_poller_tb.sv
module tbit_poller_tb;

   localparam int LIM = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        pause_i = 1'b0;
   logic        rd_o, wr_o, busy_o;
   logic [15:0] wdata_o;
   logic [15:0] rdata_i = '0;
   logic        ack_i = 1'b0;
   logic [1:0]  result_o;

   int checks = 0;
   int errors = 0;
   int n_rd = 0;
   int n_wr = 0;
   int gaps = 0;
   int sbase = 0;
   logic [15:0] last_wdata = '0;
   logic        prev_pause = 1'b0;
   logic [15:0] script [16];

   always #2 clk = ~clk;

   tbit_poller #(.MAX_PAIRS(LIM)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .pause_i  (pause_i),
      .rd_o     (rd_o),
      .wr_o     (wr_o),
      .wdata_o  (wdata_o),
      .rdata_i  (rdata_i),
      .ack_i    (ack_i),
      .busy_o   (busy_o),
      .result_o (result_o)
   );

   // Scripted flash model: acknowledges each strobe one cycle after it is seen.
   always @(negedge clk) begin
      prev_pause <= pause_i;
      if (busy_o && !rd_o && !wr_o && !pause_i && !prev_pause) gaps <= gaps + 1;
      if (ack_i) begin
         ack_i <= 1'b0;
      end else if (rd_o) begin
         ack_i   <= 1'b1;
         rdata_i <= script[(n_rd - sbase) & 15];
         n_rd    <= n_rd + 1;
      end else if (wr_o) begin
         ack_i      <= 1'b1;
         n_wr       <= n_wr + 1;
         last_wdata <= wdata_o;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400; i++) begin
         if (!busy_o) break;
         @(negedge clk);
      end
   endtask

   // Runs one poll against a script; checks result, read count, write count.
   task automatic run_poll(input string tag, input int nrd, input int nwr, input logic [1:0] res);
      int rd0 = n_rd;
      int wr0 = n_wr;
      int g0  = gaps;
      sbase = n_rd;
      pulse_start();
      check(result_o == 2'b00 && busy_o, {tag, " R9 busy code"}, result_o, 0);
      wait_idle();
      check(result_o == res, {tag, " result"}, result_o, res);
      check(n_rd - rd0 == nrd, {tag, " reads"}, n_rd - rd0, nrd);
      check(n_wr - wr0 == nwr, {tag, " writes"}, n_wr - wr0, nwr);
      check(gaps == g0, {tag, " R2 no idle bus cycle"}, gaps - g0, 0);
      if (nwr != 0) check(last_wdata == 16'h00F0, {tag, " R6 reset data"}, last_wdata, 16'h00F0);
   endtask

   task automatic t_reset();
      check(!busy_o && result_o == 2'b00 && !rd_o && !wr_o, "R1 reset state",
            {busy_o, result_o, rd_o, wr_o}, 0);
   endtask

   task automatic t_steady();
      script[0] = 16'h0040; script[1] = 16'h0040;
      run_poll("R3 steady", 2, 0, 2'b01);
   endtask

   task automatic t_toggle_then_steady();
      script[0] = 16'h0000; script[1] = 16'h0040;
      script[2] = 16'h0040; script[3] = 16'h0040;
      run_poll("R4 repoll", 4, 0, 2'b01);
   endtask

   task automatic t_recheck_ok();
      script[0] = 16'h0000; script[1] = 16'h0060;
      script[2] = 16'h0060; script[3] = 16'h0060;
      run_poll("R5 recheck ok", 4, 0, 2'b01);
   endtask

   task automatic t_recheck_fail();
      script[0] = 16'h0000; script[1] = 16'h0060;
      script[2] = 16'h0020; script[3] = 16'h0060;
      run_poll("R6 recheck fail", 4, 1, 2'b10);
   endtask

   task automatic t_limit();
      for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 16'h0000 : 16'h0040;
      run_poll("R8 limit", 2 * LIM, 1, 2'b10);
   endtask

   task automatic t_other_bits();
      script[0] = 16'hFF9F; script[1] = 16'h0000;
      run_poll("R10 other bits", 2, 0, 2'b01);
   endtask

   task automatic t_hold_result();
      logic [1:0] r = result_o;
      repeat (12) @(negedge clk);
      check(result_o == r && !busy_o, "R9 result held", result_o, r);
   endtask

   task automatic t_pause();
      int rd0 = n_rd;
      script[0] = 16'h0000; script[1] = 16'h0040;
      script[2] = 16'h0040; script[3] = 16'h0040;
      sbase = n_rd;
      pause_i = 1'b1;
      pulse_start();
      repeat (30) @(negedge clk);
      check(n_rd - rd0 == 2 && busy_o && !rd_o && !wr_o, "R7 paused reads",
            n_rd - rd0, 2);
      check(result_o == 2'b00, "R9 code while paused", result_o, 0);
      pulse_start();
      repeat (4) @(negedge clk);
      check(n_rd - rd0 == 2, "R9 start ignored while busy", n_rd - rd0, 2);
      pause_i = 1'b0;
      wait_idle();
      check(result_o == 2'b01 && n_rd - rd0 == 4 && n_wr >= 0, "R7 resume fresh pair",
            n_rd - rd0, 4);
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_steady();
      t_hold_result();
      t_toggle_then_steady();
      t_recheck_ok();
      t_recheck_fail();
      t_hold_result();
      t_limit();
      t_other_bits();
      t_pause();
      t_recheck_fail();
      check(!rd_o && !wr_o, "R11 bus idle after poll", {rd_o, wr_o}, 0);
   endtask

   initial begin
      bit wd = 1'b0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) check(1'b0, "watchdog", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule